// File: doc/BRIEF.md
# Gray Code Up Counter

This block is a synchronous up counter whose state is always a reflected Gray code word, so exactly one output bit toggles on every advance. It walks all 2^WIDTH code words (256 with the default width of 8) and then returns to its starting word. The successor word comes from arithmetic and not from a table. Each cycle the current Gray word is decoded to binary, one is added, and the sum is encoded back into Gray.

A per-cycle action decoder chooses one of four named actions. RESET forces the state to all zeros. LOAD writes an arbitrary Gray word supplied on the load bus. COUNT advances to the next code word. HOLD keeps the current word. The priority order is RESET, then LOAD, then COUNT, then HOLD. Every action can follow every other action, so the transitions are RESET->any, LOAD->any, COUNT->any and HOLD->any. The state register applies the chosen action on each rising clock edge.

Top module: `gray_up_counter`

## Requirements
- R1: While `rst` is high at a rising edge, the output becomes all zeros after that edge, whatever `load` and `enable` are doing.
- R2: When `load` is high and `rst` is low, the output becomes `load_value` after the edge, whether `enable` is high or low.
- R3: When `rst`, `load` and `enable` are all low, the output keeps its value.
- R4: When `enable` is high and `rst` and `load` are low, the output becomes the Gray encoding (b XOR (b >> 1)) of b + 1 modulo 2^WIDTH, where b is the binary value of the current Gray word. The top binary bit equals the top Gray bit, and each lower binary bit is the next-higher binary bit XOR the Gray bit at that position.
- R5: Every COUNT step changes exactly one output bit. This includes the step from the last code word back to the first.
- R6: The word that follows Gray 10000000 (binary 255) is 00000000.
- R7: Starting from any word, 2^WIDTH consecutive COUNT steps pass through every code word exactly once and then return to the start word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| load | input | 1 | Load strobe; has priority over enable |
| load_value | input | 8 | Gray word written when load is high |
| enable | input | 1 | Advance to the next Gray word |
| gray_out | output | 8 | Current Gray code state |

## Verification
Load and count can be requested in the same cycle, and reset can coincide with either of them. The bench raises `load` and `enable` together on random and directed cycles, and also pulses `rst` while `load` is high. It expects the loaded word in the first case and zero in the second, never the incremented word. A bench reference model decodes Gray with a shift-and-XOR prefix, and it judges every cycle of a long random mix of all four actions.

// File: rtl/gray_cnt_pkg.sv
package gray_cnt_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_RESET = 2'd3
    } gray_act_t;
endpackage

// File: rtl/gray_to_bin.sv
module gray_to_bin #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] gray_in,
    output logic [WIDTH-1:0] bin_out
);
    assign bin_out[WIDTH-1] = gray_in[WIDTH-1];
    generate
        for (genvar i = WIDTH - 2; i >= 0; i--) begin : g_bit
            // lower bit copies the higher binary bit, inverted when gray bit set
            assign bin_out[i] = gray_in[i] ? ~bin_out[i+1] : bin_out[i+1];
        end
    endgenerate
endmodule

// File: rtl/bin_to_gray.sv
module bin_to_gray #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] bin_in,
    output logic [WIDTH-1:0] gray_out
);
    assign gray_out = bin_in ^ (bin_in >> 1);
endmodule

// File: rtl/gray_act_decode.sv
module gray_act_decode
    import gray_cnt_pkg::*;
(
    input  logic      rst,
    input  logic      load,
    input  logic      enable,
    output gray_act_t act
);
    always_comb begin
        if (rst)         act = ACT_RESET;
        else if (load)   act = ACT_LOAD;
        else if (enable) act = ACT_COUNT;
        else             act = ACT_HOLD;
    end
endmodule

// File: rtl/gray_up_counter.sv
module gray_up_counter
    import gray_cnt_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_value,
    input  logic             enable,
    output logic [WIDTH-1:0] gray_out
);
    localparam logic [WIDTH-1:0] TOP_WORD = {1'b1, {(WIDTH-1){1'b0}}};

    gray_act_t        act;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_bin;
    logic [WIDTH-1:0] bin_inc;
    logic [WIDTH-1:0] gray_next;

    gray_act_decode u_dec (
        .rst    (rst),
        .load   (load),
        .enable (enable),
        .act    (act)
    );

    gray_to_bin #(.WIDTH(WIDTH)) u_g2b (
        .gray_in (state_q),
        .bin_out (state_bin)
    );

    // binary increment, wraps naturally at 2^WIDTH
    assign bin_inc = state_bin + 1'b1;

    bin_to_gray #(.WIDTH(WIDTH)) u_b2g (
        .bin_in   (bin_inc),
        .gray_out (gray_next)
    );

    // state register
    always_ff @(posedge clk) begin
        unique case (act)
            ACT_RESET: state_q <= '0;
            ACT_LOAD:  state_q <= load_value;
            ACT_COUNT: state_q <= gray_next;
            ACT_HOLD:  state_q <= state_q;
        endcase
    end

    // outputs
    always_comb begin
        gray_out = state_q;
    end

    // R2: load wins over enable
    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> gray_out == $past(load_value));

    // R3: idle cycle holds
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !enable) |=> $stable(gray_out));

    // R5: one bit per count step
    p_onebit_r5: assert property (@(posedge clk) disable iff (rst)
        (!load && enable) |=> $countones(gray_out ^ $past(gray_out)) == 1);

    // R6: wrap from the top word to zero
    p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && enable && gray_out == TOP_WORD) |=> gray_out == '0);
endmodule

// File: tb/gray_up_counter_test.sv
module gray_up_counter_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [7:0] load_value = 8'h00;
    logic       enable = 1'b0;
    logic [7:0] gray_out;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h00;

    always #5 clk = ~clk;

    gray_up_counter #(.WIDTH(8)) uut (
        .clk(clk), .rst(rst), .load(load), .load_value(load_value),
        .enable(enable), .gray_out(gray_out)
    );

    function automatic logic [7:0] g2b(input logic [7:0] g);
        logic [7:0] b = g;
        b = b ^ (b >> 1);
        b = b ^ (b >> 2);
        b = b ^ (b >> 4);
        return b;
    endfunction

    function automatic logic [7:0] nxt(input logic [7:0] g);
        logic [7:0] b = g2b(g) + 8'd1;
        return b ^ (b >> 1);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic [7:0] v, input logic e);
        @(negedge clk);
        rst = r; load = l; load_value = v; enable = e;
        if (r) model = 8'h00;
        else if (l) model = v;
        else if (e) model = nxt(model);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1 reset state
        step(1, 0, 8'h00, 0);
        step(1, 0, 8'h00, 0);
        check("R1 reset", gray_out, 8'h00);

        // R4 first steps of the sequence from zero
        step(0, 0, 8'h00, 1); check("R4 step1", gray_out, 8'h01);
        step(0, 0, 8'h00, 1); check("R4 step2", gray_out, 8'h03);
        step(0, 0, 8'h00, 1); check("R4 step3", gray_out, 8'h02);

        // R7 and R5 full period from a loaded word
        step(0, 1, 8'h5A, 0);
        check("R2 load", gray_out, 8'h5A);
        begin
            logic [255:0] seen = '0;
            logic [7:0] prev;
            int bad = 0;
            for (int i = 0; i < 256; i++) begin
                prev = gray_out;
                if (seen[gray_out]) bad++;
                seen[gray_out] = 1'b1;
                step(0, 0, 8'h00, 1);
                if ($countones(gray_out ^ prev) != 1) bad++;
                if (gray_out !== model) bad++;
            end
            check("R5/R7 period faults", 8'(bad), 8'h00);
            check("R7 back to start", gray_out, 8'h5A);
        end

        // R6 wrap
        step(0, 1, 8'h80, 0);
        step(0, 0, 8'h00, 1);
        check("R6 wrap", gray_out, 8'h00);

        // R2 load and enable together
        step(0, 1, 8'hC3, 1);
        check("R2 load beats enable", gray_out, 8'hC3);

        // R3 hold
        step(0, 0, 8'h00, 0);
        step(0, 0, 8'hFF, 0);
        check("R3 hold", gray_out, 8'hC3);

        // R1 reset beats load
        step(1, 1, 8'h77, 1);
        check("R1 reset beats load", gray_out, 8'h00);

        // random mix, R4 against model
        begin
            int bad = 0;
            for (int i = 0; i < 2000; i++) begin
                int r = $urandom_range(0, 99);
                step(r < 2, r >= 2 && r < 12, 8'($urandom), (r % 3) != 0);
                if (gray_out !== model) begin
                    bad++;
                    if (bad < 4) check("R4 random", gray_out, model);
                end
            end
            check("R4 random mismatches", 8'(bad), 8'h00);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule